// File: doc/BRIEF.md
# Microwire Serial Command Front-End

This block is the command side of a small serial memory reached over a three-wire Microwire-style link: chip select, serial clock and serial data in, plus serial data out. It runs on a fast system clock. It resynchronises the three incoming lines and acts on each rising edge it sees on the serial clock. It waits for a start bit, then gathers an opcode and an address. Read commands are served directly. The block fetches words through a one-cycle synchronous read port and shifts them out. Commands that change the array are handed to a separate program controller as a one-cycle strobe. That controller gathers any write data and does the timed programming itself.

The word width is set at build time. An 8-bit word uses a 9-bit address and a 16-bit word uses an 8-bit address. Read data leaves as a single leading zero, then the word with its most significant bit first. If select stays high, the next words follow from increasing addresses. A write-enable latch guards every command that modifies the array.

Top module: `mw_cmd_frontend`

## Requirements
- R1: While idle and selected, a 0 sampled on data-in at a serial clock rising edge is ignored; only a 1 begins an instruction.
- R2: After the start bit come a 2-bit opcode and then an address of 9 bits (8-bit words) or 8 bits (16-bit words), all sent most significant bit first. Opcode 10 is read, 11 is erase, 01 is write and 00 is special.
- R3: For a special instruction, the two top address bits choose the action: 11 enable, 00 disable, 10 erase-all, 01 write-all. An accepted erase, write, erase-all or write-all gives a one-cycle `cmd_valid_o` after the last address bit. It carries `cmd_addr_o` and a `cmd_op_o` code of 0 for erase, 1 for write, 2 for erase-all and 3 for write-all.
- R4: On the serial clock rising edge that carries the last address bit of a read, `do_oe_o` rises and `do_o` is 0. Each later rising edge presents one data bit, most significant bit first.
- R5: If select stays high after a word has been sent, the next rising edge starts the word at the next address. The address after the highest one is 0.
- R6: A drop of chip select throws away any partly received instruction or read. The next read needs a full start bit, opcode and address.
- R7: The write-enable latch (`wen_o`) is 0 after reset. The enable instruction sets it and the disable instruction clears it.
- R8: Reads return the same data whether the latch is set or clear.
- R9: Erase, write, erase-all and write-all received while the latch is clear produce no strobe.
- R10: `do_oe_o` is 0 during reset and drops within one cycle after the synchronised chip select is seen low.
- R11: `rd_en_o` is a one-cycle pulse. It fires once when a read address is decoded and once each time the last bit of a word is shifted out, and `rd_data_i` is taken the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_i | input | 1 | Serial chip select, asynchronous |
| sk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in, asynchronous |
| do_o | output | 1 | Serial data out |
| do_oe_o | output | 1 | Output enable for the data-out driver |
| rd_en_o | output | 1 | Read strobe to the storage array |
| rd_addr_o | output | ADDR_W | Read address to the storage array |
| rd_data_i | input | WORD_W | Read data, valid one cycle after `rd_en_o` |
| cmd_valid_o | output | 1 | Strobe for a modifying command |
| cmd_op_o | output | 2 | Command code: 0 erase, 1 write, 2 erase-all, 3 write-all |
| cmd_addr_o | output | ADDR_W | Target address of the command |
| wen_o | output | 1 | Write-enable latch state |

## Verification
The checker watches a set of rules on every cycle. It confirms that the output enable falls once select is seen low and that the first bit after the enable rises is the dummy zero. It also confirms that command and fetch strobes last one cycle, that no strobe appears while the latch is clear, and that the latch moves only on a decoded enable or disable. Other behaviour can only be seen in the directed scenarios. These cover the exact bit order of the data, the wrap from the top address to 0, the skipping of leading zeros, recovery after an aborted header or read, and the exact codes and addresses passed to the program controller.

// File: rtl/mwf_pkg.sv
package mwf_pkg;

  typedef enum logic [1:0] {
    MC_ERASE     = 2'd0,
    MC_WRITE     = 2'd1,
    MC_ERASE_ALL = 2'd2,
    MC_WRITE_ALL = 2'd3
  } mw_cmd_e;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_HDR  = 2'd1,
    RX_HOLD = 2'd2
  } rx_state_e;

  localparam logic [1:0] OPC_READ    = 2'b10;
  localparam logic [1:0] OPC_ERASE   = 2'b11;
  localparam logic [1:0] OPC_WRITE   = 2'b01;
  localparam logic [1:0] OPC_SPECIAL = 2'b00;

  localparam logic [1:0] SUB_ENABLE  = 2'b11;
  localparam logic [1:0] SUB_DISABLE = 2'b00;
  localparam logic [1:0] SUB_ERALL   = 2'b10;
  localparam logic [1:0] SUB_WRALL   = 2'b01;

  // address width follows the word organisation
  function automatic int addr_bits(input int word_w);
    return (word_w == 8) ? 9 : 8;
  endfunction

  // special sub-commands that only touch the enable latch
  function automatic logic is_latch_op(input logic [1:0] opc, input logic [1:0] sub);
    return (opc == OPC_SPECIAL) && ((sub == SUB_ENABLE) || (sub == SUB_DISABLE));
  endfunction

  // code handed to the program controller
  function automatic mw_cmd_e cmd_of(input logic [1:0] opc, input logic [1:0] sub);
    if (opc == OPC_ERASE)      return MC_ERASE;
    else if (opc == OPC_WRITE) return MC_WRITE;
    else if (sub == SUB_ERALL) return MC_ERASE_ALL;
    else                       return MC_WRITE_ALL;
  endfunction

endpackage

// File: rtl/mwf_sync.sv
module mwf_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end

endmodule

// File: rtl/mwf_cmd_rx.sv
module mwf_cmd_rx
  import mwf_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sk_rise,
  input  logic              di_s,
  output logic              rd_start,
  output logic [ADDR_W-1:0] rd_start_addr,
  output logic              cmd_valid,
  output mw_cmd_e           cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wen,
  output logic              ewen_evt,
  output logic              ewds_evt
);

  localparam int HDR_W = 2 + ADDR_W;
  localparam int CNT_W = $clog2(HDR_W);

  rx_state_e         state;
  logic [HDR_W-2:0]  hdr_q;
  logic [CNT_W-1:0]  cnt;

  logic              last_bit;
  logic [HDR_W-1:0]  hdr_full;
  logic [1:0]        opc;
  logic [1:0]        sub;
  logic [ADDR_W-1:0] adr;
  logic              mod_evt;

  assign last_bit = cs_s && sk_rise && (state == RX_HDR) && (cnt == CNT_W'(HDR_W - 1));
  assign hdr_full = {hdr_q, di_s};
  assign opc      = hdr_full[HDR_W-1 -: 2];
  assign adr      = hdr_full[ADDR_W-1:0];
  assign sub      = adr[ADDR_W-1 -: 2];

  assign rd_start      = last_bit && (opc == OPC_READ);
  assign rd_start_addr = adr;
  assign ewen_evt      = last_bit && (opc == OPC_SPECIAL) && (sub == SUB_ENABLE);
  assign ewds_evt      = last_bit && (opc == OPC_SPECIAL) && (sub == SUB_DISABLE);
  assign mod_evt       = last_bit && (opc != OPC_READ) && !is_latch_op(opc, sub);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      hdr_q     <= '0;
      cnt       <= '0;
      wen       <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_op    <= MC_ERASE;
      cmd_addr  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (ewen_evt)      wen <= 1'b1;
      else if (ewds_evt) wen <= 1'b0;
      if (mod_evt && wen) begin
        cmd_valid <= 1'b1;
        cmd_op    <= cmd_of(opc, sub);
        cmd_addr  <= adr;
      end
      if (!cs_s) begin
        state <= RX_IDLE;
        cnt   <= '0;
      end else if (sk_rise) begin
        case (state)
          RX_IDLE: if (di_s) begin
            state <= RX_HDR;
            cnt   <= '0;
          end
          RX_HDR: begin
            hdr_q <= {hdr_q[HDR_W-3:0], di_s};
            if (cnt == CNT_W'(HDR_W - 1)) state <= RX_HOLD;
            else                          cnt   <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mwf_rd_out.sv
module mwf_rd_out #(
  parameter int WORD_W = 8,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sk_rise,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_start_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              dout,
  output logic              doe,
  output logic              word_done
);

  localparam int BC_W = $clog2(WORD_W);

  logic              active;
  logic              rd_pend;
  logic [WORD_W-1:0] shreg;
  logic [BC_W-1:0]   bcnt;
  logic [ADDR_W-1:0] addr_q;

  assign rd_addr   = addr_q;
  assign word_done = cs_s && active && sk_rise && (bcnt == BC_W'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      rd_pend <= 1'b0;
      rd_en   <= 1'b0;
      shreg   <= '0;
      bcnt    <= '0;
      addr_q  <= '0;
      dout    <= 1'b0;
      doe     <= 1'b0;
    end else begin
      rd_en   <= 1'b0;
      rd_pend <= rd_en;
      if (rd_pend) shreg <= rd_data;
      if (!cs_s) begin
        active <= 1'b0;
        doe    <= 1'b0;
        dout   <= 1'b0;
      end else if (rd_start) begin
        active <= 1'b1;
        doe    <= 1'b1;
        dout   <= 1'b0;
        bcnt   <= '0;
        addr_q <= rd_start_addr;
        rd_en  <= 1'b1;
      end else if (active && sk_rise) begin
        dout  <= shreg[WORD_W-1];
        shreg <= {shreg[WORD_W-2:0], 1'b0};
        if (word_done) begin
          bcnt   <= '0;
          addr_q <= addr_q + 1'b1;
          rd_en  <= 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mw_cmd_frontend.sv
module mw_cmd_frontend
  import mwf_pkg::*;
#(
  parameter  int WORD_W = 8,
  localparam int ADDR_W = mwf_pkg::addr_bits(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              sk_i,
  input  logic              di_i,
  output logic              do_o,
  output logic              do_oe_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              wen_o
);

  logic              cs_s, sk_s, di_s;
  logic              sk_prev;
  logic              sk_rise;
  logic              rd_start;
  logic [ADDR_W-1:0] rd_start_addr;
  logic              ewen_evt, ewds_evt;
  logic              word_done;
  mw_cmd_e           cmd_op;

  mwf_sync #(.W(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_i, sk_i, di_i}),
    .q    ({cs_s, sk_s, di_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_prev <= 1'b0;
    else        sk_prev <= sk_s;
  end
  assign sk_rise = sk_s && !sk_prev;

  mwf_cmd_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_s         (cs_s),
    .sk_rise      (sk_rise),
    .di_s         (di_s),
    .rd_start     (rd_start),
    .rd_start_addr(rd_start_addr),
    .cmd_valid    (cmd_valid_o),
    .cmd_op       (cmd_op),
    .cmd_addr     (cmd_addr_o),
    .wen          (wen_o),
    .ewen_evt     (ewen_evt),
    .ewds_evt     (ewds_evt)
  );

  assign cmd_op_o = cmd_op;

  mwf_rd_out #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_s         (cs_s),
    .sk_rise      (sk_rise),
    .rd_start     (rd_start),
    .rd_start_addr(rd_start_addr),
    .rd_data      (rd_data_i),
    .rd_en        (rd_en_o),
    .rd_addr      (rd_addr_o),
    .dout         (do_o),
    .doe          (do_oe_o),
    .word_done    (word_done)
  );

endmodule

// File: rtl/mwf_chk.sv
module mwf_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic do_o,
  input logic do_oe_o,
  input logic rd_en_o,
  input logic cmd_valid_o,
  input logic wen_o,
  input logic ewen_evt,
  input logic ewds_evt
);

  // R10
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !do_oe_o);

  // R4
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(do_oe_o) |-> !do_o);

  // R3
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  // R9
  strobe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> wen_o);

  // R7
  wen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen_o) |-> $past(ewen_evt));

  // R7
  wen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wen_o) |-> $past(ewds_evt));

  // R11
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> !rd_en_o);

  // R11
  fetch_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> do_oe_o);

endmodule

bind mw_cmd_frontend mwf_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_s       (cs_s),
  .do_o       (do_o),
  .do_oe_o    (do_oe_o),
  .rd_en_o    (rd_en_o),
  .cmd_valid_o(cmd_valid_o),
  .wen_o      (wen_o),
  .ewen_evt   (ewen_evt),
  .ewds_evt   (ewds_evt)
);

// File: tb/mw_cmd_frontend_test.sv
`timescale 1ns/1ps
module mw_cmd_frontend_test;

  localparam int WW = 8;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic          do_o, do_oe_o, rd_en_o, cmd_valid_o, wen_o;
  logic [AW-1:0] rd_addr_o, cmd_addr_o;
  logic [WW-1:0] rd_data_i;
  logic [1:0]    cmd_op_o;

  int checks = 0;
  int errors = 0;
  int n_strobe = 0;
  int n_fetch = 0;
  logic [1:0]    last_op;
  logic [AW-1:0] last_addr;

  always #2.5 clk = ~clk;

  mw_cmd_frontend #(.WORD_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_o), .do_oe_o(do_oe_o), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
    .cmd_addr_o(cmd_addr_o), .wen_o(wen_o)
  );

  function automatic logic [WW-1:0] model_word(input int a);
    return WW'((a * 29 + 7) ^ (a >> 3));
  endfunction

  logic [WW-1:0] mem [2**AW];
  initial for (int i = 0; i < 2**AW; i++) mem[i] = model_word(i);
  always @(posedge clk) if (rd_en_o) rd_data_i <= mem[rd_addr_o];

  always @(negedge clk) begin
    if (cmd_valid_o) begin
      n_strobe++;
      last_op   = cmd_op_o;
      last_addr = cmd_addr_o;
    end
    if (rd_en_o) n_fetch++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b, output logic d);
    di = b;
    clk_n(4);
    sk = 1'b1;
    clk_n(4);
    d = do_o;
    sk = 1'b0;
  endtask

  task automatic cs_up;
    cs = 1'b1;
    clk_n(4);
  endtask

  task automatic cs_down;
    cs = 1'b0;
    di = 1'b0;
    clk_n(6);
  endtask

  task automatic send_hdr(input logic [1:0] opc, input logic [AW-1:0] a, output logic d);
    pulse(1'b1, d);
    for (int i = 1; i >= 0; i--) pulse(opc[i], d);
    for (int i = AW - 1; i >= 0; i--) pulse(a[i], d);
  endtask

  task automatic read_words(input string req, input int a, input int n);
    logic d;
    logic [WW-1:0] w;
    send_hdr(2'b10, AW'(a), d);
    check({req, " dummy bit"}, int'(d), 0);
    check({req, " oe driven"}, int'(do_oe_o), 1);
    for (int k = 0; k < n; k++) begin
      for (int b = WW - 1; b >= 0; b--) begin
        pulse(1'b0, d);
        w[b] = d;
      end
      check({req, " word"}, int'(w), int'(model_word((a + k) % (2**AW))));
    end
  endtask

  task automatic do_read(input string req, input int a, input int n);
    cs_up;
    read_words(req, a, n);
    cs_down;
    check("R10 oe released", int'(do_oe_o), 0);
  endtask

  task automatic issue(input logic [1:0] opc, input logic [AW-1:0] a);
    logic d;
    cs_up;
    send_hdr(opc, a, d);
    cs_down;
  endtask

  localparam logic [AW-1:0] A_EN   = {2'b11, {(AW-2){1'b0}}};
  localparam logic [AW-1:0] A_DIS  = {2'b00, {(AW-2){1'b1}}};
  localparam logic [AW-1:0] A_ERAL = {2'b10, {(AW-2){1'b0}}};
  localparam logic [AW-1:0] A_WRAL = {2'b01, {(AW-2){1'b1}}};

  task automatic t_reset;
    check("R10 oe at reset", int'(do_oe_o), 0);
    check("R7 latch at reset", int'(wen_o), 0);
    check("R3 no strobe at reset", n_strobe, 0);
  endtask

  task automatic t_read;
    do_read("R4 R2 read 005", 5, 1);
    do_read("R4 R2 read 0AA", 9'h0AA, 1);
  endtask

  task automatic t_wrap;
    int f0 = n_fetch;
    do_read("R5 wrap read", 9'h1FE, 3);
    check("R11 fetch count", n_fetch - f0, 4);
  endtask

  task automatic t_locked;
    int s0 = n_strobe;
    logic d;
    cs_up;
    send_hdr(2'b01, 9'h123, d);
    for (int i = 0; i < WW; i++) pulse(1'b1, d);
    cs_down;
    issue(2'b11, 9'h045);
    issue(2'b00, A_ERAL);
    issue(2'b00, A_WRAL);
    check("R9 no strobe while locked", n_strobe - s0, 0);
    check("R9 latch still clear", int'(wen_o), 0);
  endtask

  task automatic t_enable;
    int s0;
    issue(2'b00, A_EN);
    check("R7 enable sets latch", int'(wen_o), 1);
    s0 = n_strobe;
    issue(2'b01, 9'h123);
    check("R3 write strobe", n_strobe - s0, 1);
    check("R3 write code", int'(last_op), 1);
    check("R3 write addr", int'(last_addr), 9'h123);
    issue(2'b11, 9'h045);
    check("R3 erase code", int'(last_op), 0);
    check("R3 erase addr", int'(last_addr), 9'h045);
    issue(2'b00, A_ERAL);
    check("R3 erase-all code", int'(last_op), 2);
    issue(2'b00, A_WRAL);
    check("R3 write-all code", int'(last_op), 3);
    check("R3 strobe total", n_strobe - s0, 4);
    do_read("R8 read with latch set", 9'h010, 2);
  endtask

  task automatic t_disable;
    int s0;
    issue(2'b00, A_DIS);
    check("R7 disable clears latch", int'(wen_o), 0);
    s0 = n_strobe;
    issue(2'b11, 9'h001);
    check("R9 erase dropped after disable", n_strobe - s0, 0);
    do_read("R8 read with latch clear", 9'h010, 1);
  endtask

  task automatic t_zeros;
    logic d;
    cs_up;
    for (int i = 0; i < 3; i++) pulse(1'b0, d);
    check("R1 idle during zeros", int'(do_oe_o), 0);
    read_words("R1 read after zeros", 9'h033, 1);
    cs_down;
  endtask

  task automatic t_abort;
    logic d;
    int s0;
    issue(2'b00, A_EN);
    s0 = n_strobe;
    cs_up;
    pulse(1'b1, d);
    pulse(1'b1, d);
    pulse(1'b1, d);
    for (int i = 0; i < 4; i++) pulse(1'b1, d);
    cs_down;
    check("R6 partial erase dropped", n_strobe - s0, 0);
    do_read("R6 read after aborted header", 9'h077, 1);
    cs_up;
    read_words("R6 partial read", 9'h100, 0);
    for (int i = 0; i < 3; i++) pulse(1'b0, d);
    cs_down;
    check("R6 R10 oe after aborted read", int'(do_oe_o), 0);
    do_read("R6 read after aborted read", 9'h0F0, 1);
    issue(2'b00, A_DIS);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clk_n(5);
    rst_n = 1'b1;
    clk_n(5);
    t_reset;
    t_read;
    t_wrap;
    t_locked;
    t_enable;
    t_disable;
    t_zeros;
    t_abort;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule